// File: doc/BRIEF.md
# Guarded Load/Store Memory Unit

This block carries out one memory operation at a time for a 32-bit processor datapath. A request carries an operation class (access width, signed or unsigned, load or store), an addressing mode, two register operands, a 32-bit immediate, a guard register value and a byte-order select. The unit forms the effective address and checks that the request is legal and that the access is aligned. It then sends the access to a byte-addressable data memory with byte enables, or to a separate port for memory-mapped registers. A load ends with a zero- or sign-extended 32-bit value and a writeback enable. A store takes its data from the second register operand, so stores can only use displacement addressing.

The request side is a valid/ready stream. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response side is also valid/ready. Once `resp_valid` rises, the response and its fields stay unchanged until `resp_ready` is seen high on a clock edge. No new request is taken until that response has been consumed.

The data memory has a fixed latency: read data is valid on the cycle after `mem_en`. The register port holds `mmio_valid` until `mmio_ready` arrives, or until a parameterised number of cycles passes with no reply.

Top module: `glsu_top`

## Requirements
- R1: An operation takes effect only when bit 0 of `req_guard` is 1. When it is 0, the response has `resp_wb_en`=0, `resp_illegal`=0 and `resp_data`=0, and neither `mem_en` nor `mmio_valid` is raised.
- R2: The effective address depends on the mode. Mode 0 (displacement) gives base+imm. Mode 1 (index) gives base+index. Mode 2 (scaled) gives base+(index<<size). The size code is 0 for byte, 1 for 16-bit and 2 for 32-bit.
- R3: Some requests are illegal: mode 3, size code 3, a store whose mode is not 0, and a byte access in mode 2. When the guard is set, an illegal request returns `resp_illegal`=1 and `resp_wb_en`=0 and makes no memory or register-port access.
- R4: Memory lane k of `mem_be`/`mem_wdata`/`mem_rdata` (bits 8k+7..8k) holds the byte at offset k of the addressed word. When `big_endian`=0, the least significant byte of the value sits at the lowest address. When it is 1, the most significant byte does. This applies to both loads and stores.
- R5: A byte or 16-bit load with `req_signed`=1 is sign-extended to 32 bits. With `req_signed`=0 it is zero-extended.
- R6: A 16-bit access needs an even address and a 32-bit access needs an address that is a multiple of 4. A misaligned store writes nothing. A misaligned load makes no memory access and returns 0 with `resp_wb_en`=1 and no fault.
- R7: Data memory covers addresses below `MEM_BYTES`. A load at or above that limit (outside the register aperture) returns 0 with no fault and no access. A store there writes nothing.
- R8: An aligned 32-bit access whose address lies in the 2 MB region at `MMIO_BASE` goes out on the register port unchanged, and `big_endian` has no effect on it. A load returns `mmio_rdata` exactly as received.
- R9: If `mmio_ready` does not arrive within `TIMEOUT` cycles of `mmio_valid`, the access ends. A store is dropped, and a load returns 0 with `resp_wb_en`=1.
- R10: A non-32-bit or misaligned access inside the register aperture behaves like an access to a register that does not exist. `mmio_valid` stays low, the response follows after the timeout, a load returns 0 and a store has no effect.
- R11: Only one operation is in flight at a time, and `mem_en` and `mmio_valid` are never high together. Memory byte enables cover exactly the bytes that are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this edge if valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_mode | input | 2 | 0 displacement, 1 index, 2 scaled index |
| req_base | input | 32 | Base register operand |
| req_index | input | 32 | Index register operand, or store data |
| req_imm | input | 32 | Displacement |
| req_guard | input | 32 | Guard register; bit 0 enables the operation |
| big_endian | input | 1 | Byte-order select, sampled with the request |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | 32 | Load result |
| resp_wb_en | output | 1 | Register writeback enable |
| resp_illegal | output | 1 | Illegal request indication |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 30 | Memory word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_en |
| mmio_valid | output | 1 | Register-port access request |
| mmio_ready | input | 1 | Register-port completion |
| mmio_we | output | 1 | Register-port write |
| mmio_addr | output | 32 | Register byte address |
| mmio_wdata | output | 32 | Register write data |
| mmio_rdata | input | 32 | Register read data |

## Verification
The assertions check on every cycle the rules that cover any single state. The two ports are never active together, and neither is active for a guarded-off or illegal operation. A register-port access is always an aligned word inside the aperture. A memory access touches only in-range addresses with as many lanes as the access width. A response is held stable under back-pressure, and the timeout wait never runs past its limit. Only the bench scenarios can show values across operations. They show the effective address of each mode and the lane placement in both byte orders, through store-then-load round trips. They also show sign and zero extension, that suppressed stores leave memory unchanged, that register-port data bypasses byte ordering, and how many cycles the timeout takes.

// File: rtl/glsu_pkg.sv
package glsu_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    AM_DISP   = 2'd0,
    AM_INDEX  = 2'd1,
    AM_SCALED = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  // where an accepted operation is sent
  typedef enum logic [1:0] {
    PATH_DONE = 2'd0,  // no access, answer at once
    PATH_MEM  = 2'd1,  // data memory
    PATH_MMIO = 2'd2,  // register port
    PATH_NXR  = 2'd3   // aperture hit that no register can serve
  } path_e;

  typedef struct packed {
    logic            guard;
    logic            illegal;
    logic            store;
    logic            sext;
    logic            big;
    size_e           size;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] wdata;
  } op_t;
endpackage

// File: rtl/glsu_agen.sv
module glsu_agen
  import glsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] MMIO_BASE = 32'h0020_0000,
  parameter int unsigned AP_LSB    = 21
) (
  input  logic [1:0]      size,
  input  logic [1:0]      mode,
  input  logic            store,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] ea,
  output logic            illegal,
  output logic            aligned,
  output logic            in_aperture,
  output logic            in_range
);
  localparam logic [XLEN-1:0] LIMIT = XLEN'(MEM_BYTES);

  logic [XLEN-1:0] offset;

  always_comb begin
    case (amode_e'(mode))
      AM_INDEX:  offset = index;
      AM_SCALED: offset = index << size;
      default:   offset = imm;
    endcase
  end

  assign ea = base + offset;

  always_comb begin
    illegal = 1'b0;
    if (amode_e'(mode) == AM_RSVD) illegal = 1'b1;
    if (size_e'(size) == SZ_RSVD) illegal = 1'b1;
    if (store && (amode_e'(mode) != AM_DISP)) illegal = 1'b1;
    if ((amode_e'(mode) == AM_SCALED) && (size_e'(size) == SZ_BYTE)) illegal = 1'b1;
  end

  always_comb begin
    case (size_e'(size))
      SZ_HALF: aligned = ~ea[0];
      SZ_WORD: aligned = (ea[1:0] == 2'b00);
      default: aligned = 1'b1;
    endcase
  end

  assign in_aperture = (ea[XLEN-1:AP_LSB] == MMIO_BASE[XLEN-1:AP_LSB]);
  assign in_range    = (ea < LIMIT);
endmodule

// File: rtl/glsu_store_lanes.sv
module glsu_store_lanes
  import glsu_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [1:0]         off,
  input  logic [1:0]         size,
  input  logic               big,
  input  logic [XLEN-1:0]    data,
  output logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] lanes
);
  logic [2:0] nbytes;
  assign nbytes = 3'd1 << size;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [2:0] K = 3'(k);
    logic [2:0] rel;
    logic [2:0] src;
    logic       on;
    // position of this lane inside the access, counted from the lowest address
    assign rel = K - {1'b0, off};
    assign on  = (K >= {1'b0, off}) && (rel < nbytes);
    assign src = big ? (nbytes - 3'd1 - rel) : rel;
    assign be[k] = on;
    assign lanes[8*k +: 8] = on ? data[{src[1:0], 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/glsu_load_extract.sv
module glsu_load_extract
  import glsu_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] word,
  input  logic [1:0]         off,
  input  logic [1:0]         size,
  input  logic               big,
  input  logic               sext,
  output logic [XLEN-1:0]    value
);
  logic [2:0]      nbytes;
  logic [XLEN-1:0] raw;
  logic            msb;

  assign nbytes = 3'd1 << size;

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    localparam logic [2:0] J = 3'(j);
    logic [2:0] pos;
    logic [2:0] lane;
    // value byte j comes from this address position of the access
    assign pos  = big ? (nbytes - 3'd1 - J) : J;
    assign lane = {1'b0, off} + pos;
    assign raw[8*j +: 8] = (J < nbytes) ? word[{lane[1:0], 3'b000} +: 8] : 8'h00;
  end

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: msb = raw[7];
      SZ_HALF: msb = raw[15];
      default: msb = raw[31];
    endcase
    value = raw;
    for (int j = 0; j < LANES; j++) begin
      if (3'(j) >= nbytes) value[8*j +: 8] = {8{sext & msb}};
    end
  end
endmodule

// File: rtl/glsu_ctrl.sv
module glsu_ctrl
  import glsu_pkg::*;
#(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  path_e path_d,
  input  logic  q_store,
  input  logic  mmio_ready,
  input  logic  resp_ready,
  output logic  req_ready,
  output logic  mem_en,
  output logic  mem_we,
  output logic  mmio_valid,
  output logic  resp_valid,
  output logic  cap_mem,
  output logic  cap_mmio
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MEM  = 3'd1,
    S_LDW  = 3'd2,
    S_MMIO = 3'd3,
    S_NXR  = 3'd4,
    S_RESP = 3'd5
  } st_e;

  st_e           state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          case (path_d)
            PATH_MEM:  state_d = S_MEM;
            PATH_MMIO: state_d = S_MMIO;
            PATH_NXR:  state_d = S_NXR;
            default:   state_d = S_RESP;
          endcase
        end
      end
      S_MEM:  state_d = q_store ? S_RESP : S_LDW;
      S_LDW:  state_d = S_RESP;
      S_MMIO: begin
        if (mmio_ready || (cnt_q == LAST)) state_d = S_RESP;
        else cnt_d = cnt_q + 1'b1;
      end
      S_NXR: begin
        if (cnt_q == LAST) state_d = S_RESP;
        else cnt_d = cnt_q + 1'b1;
      end
      S_RESP: if (resp_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign mem_en     = (state_q == S_MEM);
  assign mem_we     = mem_en & q_store;
  assign mmio_valid = (state_q == S_MMIO);
  assign resp_valid = (state_q == S_RESP);
  assign cap_mem    = (state_q == S_LDW);
  assign cap_mmio   = mmio_valid & mmio_ready & ~q_store;

  // R9: a register-port wait never outlasts the timeout window
  a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_MMIO) || (state_q == S_NXR)) |-> (cnt_q <= LAST));

  // R9: an unanswered access at the end of the window closes
  a_r9_timeout_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_MMIO) && (cnt_q == LAST) && !mmio_ready) |=> (state_q == S_RESP));
endmodule

// File: rtl/glsu_top.sv
module glsu_top
  import glsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] MMIO_BASE = 32'h0020_0000,
  parameter int unsigned TIMEOUT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [1:0]  req_mode,
  input  logic [31:0] req_base,
  input  logic [31:0] req_index,
  input  logic [31:0] req_imm,
  input  logic [31:0] req_guard,
  input  logic        big_endian,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [31:0] resp_data,
  output logic        resp_wb_en,
  output logic        resp_illegal,
  output logic        mem_en,
  output logic        mem_we,
  output logic [29:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        mmio_valid,
  input  logic        mmio_ready,
  output logic        mmio_we,
  output logic [31:0] mmio_addr,
  output logic [31:0] mmio_wdata,
  input  logic [31:0] mmio_rdata
);
  localparam int unsigned AP_LSB = 21;   // 2 MB aperture
  localparam int unsigned LANES  = XLEN / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  logic            fire;
  logic [XLEN-1:0] ea;
  logic            illegal, aligned, in_ap, in_range;
  path_e           path_d;
  op_t             op_q;
  logic            cap_mem, cap_mmio;
  logic [XLEN-1:0] ld_value;
  logic [XLEN-1:0] data_q;

  glsu_agen #(
    .MEM_BYTES (MEM_BYTES),
    .MMIO_BASE (MMIO_BASE),
    .AP_LSB    (AP_LSB)
  ) u_agen (
    .size        (req_size),
    .mode        (req_mode),
    .store       (req_store),
    .base        (req_base),
    .index       (req_index),
    .imm         (req_imm),
    .ea          (ea),
    .illegal     (illegal),
    .aligned     (aligned),
    .in_aperture (in_ap),
    .in_range    (in_range)
  );

  // routing decision, highest priority first
  always_comb begin
    if (!req_guard[0] || illegal)
      path_d = PATH_DONE;
    else if (in_ap)
      path_d = ((size_e'(req_size) == SZ_WORD) && aligned) ? PATH_MMIO : PATH_NXR;
    else if (!in_range || !aligned)
      path_d = PATH_DONE;
    else
      path_d = PATH_MEM;
  end

  assign fire = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (fire) begin
      op_q.guard   <= req_guard[0];
      op_q.illegal <= illegal;
      op_q.store   <= req_store;
      op_q.sext    <= req_signed;
      op_q.big     <= big_endian;
      op_q.size    <= size_e'(req_size);
      op_q.ea      <= ea;
      op_q.wdata   <= req_index;
    end
  end

  glsu_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .path_d     (path_d),
    .q_store    (op_q.store),
    .mmio_ready (mmio_ready),
    .resp_ready (resp_ready),
    .req_ready  (req_ready),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mmio_valid (mmio_valid),
    .resp_valid (resp_valid),
    .cap_mem    (cap_mem),
    .cap_mmio   (cap_mmio)
  );

  glsu_store_lanes #(.LANES(LANES)) u_stl (
    .off   (op_q.ea[OFF_W-1:0]),
    .size  (op_q.size),
    .big   (op_q.big),
    .data  (op_q.wdata),
    .be    (mem_be),
    .lanes (mem_wdata)
  );

  glsu_load_extract #(.LANES(LANES)) u_ldx (
    .word  (mem_rdata),
    .off   (op_q.ea[OFF_W-1:0]),
    .size  (op_q.size),
    .big   (op_q.big),
    .sext  (op_q.sext),
    .value (ld_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (fire)     data_q <= '0;
    else if (cap_mem)  data_q <= ld_value;
    else if (cap_mmio) data_q <= mmio_rdata;
  end

  assign mem_addr     = op_q.ea[XLEN-1:OFF_W];
  assign mmio_addr    = op_q.ea;
  assign mmio_wdata   = op_q.wdata;
  assign mmio_we      = mmio_valid & op_q.store;
  assign resp_data    = data_q;
  assign resp_wb_en   = resp_valid & op_q.guard & ~op_q.illegal & ~op_q.store;
  assign resp_illegal = resp_valid & op_q.guard & op_q.illegal;

  // R11: the two access ports are exclusive
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && mmio_valid));

  // R11: a new request is only taken with nothing outstanding
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!resp_valid && !mem_en && !mmio_valid));

  // R11: response held under back-pressure
  a_r11_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)
                                     && $stable(resp_wb_en) && $stable(resp_illegal)));

  // R1 / R3: a gated or illegal operation never reaches a port
  a_r1_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en || mmio_valid) |-> (op_q.guard && !op_q.illegal));

  // R3: a fault never comes with a writeback
  a_r3_illegal_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    resp_illegal |-> !resp_wb_en);

  // R8: register port only sees aligned words in the aperture
  a_r8_mmio_word: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_valid |-> ((op_q.size == SZ_WORD) && (mmio_addr[1:0] == 2'b00)
                    && (mmio_addr[XLEN-1:AP_LSB] == MMIO_BASE[XLEN-1:AP_LSB])));

  // R6 / R11: lane count matches the access width
  a_r6_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == (32'd1 << op_q.size)));

  // R7: memory strobes stay inside the valid range
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ({mem_addr, 2'b00} < XLEN'(MEM_BYTES)));
endmodule

// File: tb/glsu_top_tb.sv
`timescale 1ns/1ps
module glsu_top_tb;
  localparam int unsigned MEM_BYTES = 256;
  localparam logic [31:0] MMIO_BASE = 32'h0020_0000;
  localparam int unsigned TIMEOUT   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
  logic [1:0]  req_size = 2'd0, req_mode = 2'd0;
  logic [31:0] req_base = '0, req_index = '0, req_imm = '0, req_guard = '0;
  logic        resp_ready = 1'b0;
  logic        req_ready, resp_valid, resp_wb_en, resp_illegal;
  logic [31:0] resp_data;
  logic        mem_en, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mmio_valid, mmio_ready, mmio_we;
  logic [31:0] mmio_addr, mmio_wdata, mmio_rdata;

  always #4 clk = ~clk;  // 125 MHz

  glsu_top #(.MEM_BYTES(MEM_BYTES), .MMIO_BASE(MMIO_BASE), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_signed(req_signed), .req_mode(req_mode),
    .req_base(req_base), .req_index(req_index), .req_imm(req_imm), .req_guard(req_guard),
    .big_endian(big_endian), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_wb_en(resp_wb_en), .resp_illegal(resp_illegal),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mmio_valid(mmio_valid),
    .mmio_ready(mmio_ready), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
    .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata)
  );

  // ---------------- device-side models ----------------
  logic [31:0] dmem [0:63];
  logic [31:0] dreg [0:1];

  initial begin
    for (int w = 0; w < 64; w++)
      for (int k = 0; k < 4; k++) dmem[w][8*k +: 8] = 8'((4*w + k) * 7 + 3);
    dreg[0] = 32'hCAFE_0001;
    dreg[1] = 32'hBEEF_0002;
  end

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= dmem[mem_addr[5:0]];
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) dmem[mem_addr[5:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
    if (mmio_valid && mmio_ready && mmio_we) dreg[mmio_addr[2]] <= mmio_wdata;
  end

  assign mmio_ready = mmio_valid && (mmio_addr == MMIO_BASE || mmio_addr == MMIO_BASE + 32'd4);
  assign mmio_rdata = dreg[mmio_addr[2]];

  // ---------------- reference state ----------------
  logic [7:0]  ref_mem [0:MEM_BYTES-1];
  logic [31:0] ref_reg [0:1];
  initial begin
    for (int a = 0; a < MEM_BYTES; a++) ref_mem[a] = 8'(a * 7 + 3);
    ref_reg[0] = 32'hCAFE_0001;
    ref_reg[1] = 32'hBEEF_0002;
  end

  int n_checks = 0, n_errors = 0;
  int cnt_wr = 0, cnt_rd = 0, cnt_mmio = 0;
  logic [3:0] exp_be = '0;
  string      cur_tag = "R11";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-clock monitor compared against the reference expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) cnt_wr++;
      if (mem_en && !mem_we) cnt_rd++;
      if (mmio_valid) cnt_mmio++;
      if (mem_en) chk(cur_tag, "byte enables", {28'd0, mem_be}, {28'd0, exp_be});
    end
  end

  task automatic do_op(string tag, logic [31:0] g, logic st, logic [1:0] sz, logic sg,
                       logic [1:0] md, logic [31:0] b, logic [31:0] x, logic [31:0] im,
                       logic bg, int hold);
    logic [31:0] ea, exp_data, off;
    logic        ill, ali, inap, exp_wb, exp_ill;
    int          n, ewr, erd, emm, wd;
    n = 1 << sz;
    case (md)
      2'd1: off = x;
      2'd2: off = x << sz;
      default: off = im;
    endcase
    ea = b + off;
    ill = (md == 2'd3) || (sz == 2'd3) || (st && md != 2'd0) || (md == 2'd2 && sz == 2'd0);
    ali = (sz == 2'd1) ? !ea[0] : (sz == 2'd2) ? (ea[1:0] == 2'b00) : 1'b1;
    inap = (ea[31:21] == MMIO_BASE[31:21]);
    exp_data = '0; ewr = 0; erd = 0; emm = 0;
    exp_ill = g[0] && ill;
    exp_wb = g[0] && !ill && !st;
    exp_be = 4'(((1 << n) - 1) << ea[1:0]);
    if (g[0] && !ill) begin
      if (inap) begin
        if (sz == 2'd2 && ali) begin
          if (ea == MMIO_BASE || ea == MMIO_BASE + 32'd4) begin
            emm = 1;
            if (st) ref_reg[ea[2]] = x;
            else exp_data = ref_reg[ea[2]];
          end else emm = TIMEOUT;
        end
      end else if (ea < MEM_BYTES && ali) begin
        if (st) begin
          ewr = 1;
          for (int i = 0; i < n; i++) ref_mem[ea + i] = x[8*(bg ? n-1-i : i) +: 8];
        end else begin
          erd = 1;
          for (int i = 0; i < n; i++) exp_data[8*(bg ? n-1-i : i) +: 8] = ref_mem[ea + i];
          if (sg && exp_data[8*n-1]) for (int i = n; i < 4; i++) exp_data[8*i +: 8] = 8'hFF;
        end
      end
    end
    @(negedge clk);
    cur_tag = tag;
    cnt_wr = 0; cnt_rd = 0; cnt_mmio = 0;
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg; req_mode = md;
    req_base = b; req_index = x; req_imm = im; req_guard = g; big_endian = bg;
    @(negedge clk);
    req_valid = 1'b0;
    big_endian = ~bg;  // later changes must not matter
    wd = 0;
    while (!resp_valid && wd < 300) begin
      @(negedge clk);
      wd++;
    end
    chk(tag, "response arrived", {31'd0, resp_valid}, 32'd1);
    chk(tag, "load data", resp_data, exp_data);
    chk(tag, "writeback enable", {31'd0, resp_wb_en}, {31'd0, exp_wb});
    chk(tag, "illegal flag", {31'd0, resp_illegal}, {31'd0, exp_ill});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R11", "held valid", {31'd0, resp_valid}, 32'd1);
      chk("R11", "held data", resp_data, exp_data);
      chk("R11", "no accept while busy", {31'd0, req_ready}, 32'd0);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(tag, "memory writes", 32'(cnt_wr), 32'(ewr));
    chk(tag, "memory reads", 32'(cnt_rd), 32'(erd));
    chk(tag, "register-port cycles", 32'(cnt_mmio), 32'(emm));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  localparam logic [31:0] G1 = 32'h0000_0001;
  localparam logic [31:0] G0 = 32'hFFFF_FFFE;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R11", "reset resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R11", "reset ports idle", {30'd0, mem_en, mmio_valid}, 32'd0);

    // R2 / R4: word round trips in both orders
    do_op("R4", G1, 1, 2'd2, 0, 2'd0, 32'h10, 32'h1122_3344, 32'h0, 1'b0, 0);
    do_op("R4", G1, 0, 2'd2, 0, 2'd0, 32'h08, 32'h0, 32'h8, 1'b0, 0);
    do_op("R4", G1, 0, 2'd2, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b1, 0);
    do_op("R4", G1, 1, 2'd1, 0, 2'd0, 32'h20, 32'h0000_ABCD, 32'h2, 1'b1, 0);
    do_op("R5", G1, 0, 2'd1, 0, 2'd0, 32'h22, 32'h0, 32'h0, 1'b0, 0);
    do_op("R5", G1, 0, 2'd1, 1, 2'd0, 32'h22, 32'h0, 32'h0, 1'b0, 0);
    do_op("R5", G1, 0, 2'd0, 1, 2'd0, 32'h23, 32'h0, 32'h0, 1'b0, 0);
    do_op("R5", G1, 0, 2'd0, 0, 2'd0, 32'h23, 32'h0, 32'h0, 1'b0, 0);
    // R2: index and scaled forms
    do_op("R2", G1, 0, 2'd2, 0, 2'd1, 32'h0C, 32'h4, 32'h0, 1'b0, 0);
    do_op("R2", G1, 0, 2'd1, 1, 2'd2, 32'h1C, 32'h3, 32'h0, 1'b1, 0);
    do_op("R2", G1, 0, 2'd2, 0, 2'd2, 32'h08, 32'h2, 32'h0, 1'b0, 0);
    do_op("R2", G1, 0, 2'd0, 0, 2'd1, 32'h13, 32'h0, 32'h0, 1'b0, 0);
    // byte sweep in alternating orders, then word read-back
    for (int i = 0; i < 8; i++)
      do_op("R4", G1, 1, 2'd0, 0, 2'd0, 32'h40, 32'(i * 37 + 128), 32'(i), 1'(i % 2), 0);
    for (int i = 0; i < 8; i++)
      do_op("R5", G1, 0, 2'd0, 1'(i % 2), 2'd0, 32'h40, 32'h0, 32'(i), 1'b0, 0);
    do_op("R4", G1, 0, 2'd2, 0, 2'd0, 32'h40, 32'h0, 32'h0, 1'b1, 0);
    do_op("R4", G1, 0, 2'd2, 0, 2'd0, 32'h44, 32'h0, 32'h0, 1'b0, 0);
    // R1: guard off, then show memory unchanged
    do_op("R1", G0, 1, 2'd2, 0, 2'd0, 32'h10, 32'hDEAD_DEAD, 32'h0, 1'b0, 0);
    do_op("R1", G0, 0, 2'd2, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b0, 0);
    do_op("R1", G1, 0, 2'd2, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b0, 0);
    do_op("R1", G0, 1, 2'd2, 0, 2'd0, MMIO_BASE, 32'h5555_5555, 32'h0, 1'b0, 0);
    // R3: illegal forms
    do_op("R3", G1, 1, 2'd2, 0, 2'd1, 32'h10, 32'h4, 32'h0, 1'b0, 0);
    do_op("R3", G1, 1, 2'd1, 0, 2'd2, 32'h10, 32'h4, 32'h0, 1'b0, 0);
    do_op("R3", G1, 0, 2'd0, 0, 2'd2, 32'h10, 32'h4, 32'h0, 1'b0, 0);
    do_op("R3", G1, 0, 2'd2, 0, 2'd3, 32'h10, 32'h4, 32'h0, 1'b0, 0);
    do_op("R3", G1, 0, 2'd3, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b0, 0);
    do_op("R3", G0, 1, 2'd2, 0, 2'd1, 32'h10, 32'h4, 32'h0, 1'b0, 0);
    do_op("R3", G1, 0, 2'd2, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b0, 0);
    // R6: misaligned
    do_op("R6", G1, 1, 2'd2, 0, 2'd0, 32'h31, 32'h7777_7777, 32'h0, 1'b0, 0);
    do_op("R6", G1, 1, 2'd1, 0, 2'd0, 32'h35, 32'h7777_7777, 32'h0, 1'b0, 0);
    do_op("R6", G1, 0, 2'd1, 1, 2'd0, 32'h11, 32'h0, 32'h0, 1'b0, 0);
    do_op("R6", G1, 0, 2'd2, 0, 2'd0, 32'h30, 32'h0, 32'h0, 1'b0, 0);
    do_op("R6", G1, 0, 2'd2, 0, 2'd0, 32'h34, 32'h0, 32'h0, 1'b0, 0);
    // R7: outside memory
    do_op("R7", G1, 0, 2'd2, 0, 2'd0, 32'h400, 32'h0, 32'h0, 1'b0, 0);
    do_op("R7", G1, 1, 2'd2, 0, 2'd0, 32'h100, 32'h1234_5678, 32'h0, 1'b0, 0);
    do_op("R7", G1, 0, 2'd2, 0, 2'd0, 32'hFC, 32'h0, 32'h0, 1'b0, 0);
    // R8: register port, byte order ignored
    do_op("R8", G1, 1, 2'd2, 0, 2'd0, MMIO_BASE, 32'hA1B2_C3D4, 32'h0, 1'b1, 0);
    do_op("R8", G1, 0, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0, 32'h0, 1'b1, 0);
    do_op("R8", G1, 0, 2'd2, 0, 2'd1, MMIO_BASE, 32'h4, 32'h0, 1'b0, 0);
    // R9: unanswered register
    do_op("R9", G1, 1, 2'd2, 0, 2'd0, MMIO_BASE, 32'h9999_9999, 32'h8, 1'b0, 0);
    do_op("R9", G1, 0, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0, 32'h1F_FFFC, 1'b0, 0);
    do_op("R9", G1, 0, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0, 32'h4, 1'b1, 0);
    // R10: narrow or misaligned aperture access
    do_op("R10", G1, 0, 2'd1, 0, 2'd0, MMIO_BASE, 32'h0, 32'h0, 1'b0, 0);
    do_op("R10", G1, 1, 2'd0, 0, 2'd0, MMIO_BASE, 32'h0000_0011, 32'h0, 1'b0, 0);
    do_op("R10", G1, 1, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0000_0022, 32'h2, 1'b0, 0);
    do_op("R10", G1, 0, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0, 32'h0, 1'b0, 0);
    // R11: back-pressure on responses
    do_op("R11", G1, 0, 2'd2, 0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b1, 5);
    do_op("R11", G1, 0, 2'd2, 0, 2'd0, MMIO_BASE, 32'h0, 32'h4, 1'b0, 3);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule